// File: doc/BRIEF.md
# Write-Hit Counting Test Target

This block is a bus target that lets a test program measure how a host issues byte writes. It decodes two byte-wide access windows: a memory window and an I/O window. The host picks one of six tests by writing a test number to offset 0 of either window. The chosen test is the window type combined with one of three test kinds: plain, wildcard and data-match.

While a test is running, the host can read a small header from either window. The header holds the test index, the access width, the trigger offset, the match byte, a hit counter and an ASCII name. Each write to the trigger offset through the test's own window adds one to the counter when the test kind's rule is met. Reads are combinational: the byte appears on the read data output in the same cycle as the address.

Top module: `write_hit_probe`

## Requirements
- R1: After reset no test is active, and every read from either window returns 0x00.
- R2: A write of value v < 3 to offset 0 of a window makes test (3*t + v) active, where t is 0 for the memory window and 1 for the I/O window. The same write clears the hit counter to 0.
- R3: A write of value 3 or more to offset 0 of either window stops any running test and leaves no test active.
- R4: Header layout, little-endian. Byte 0 holds the test index and byte 1 holds 1 (the access width). Bytes 4..7 hold the trigger offset, which is base + index, with base 2048 for tests 0..2 and 128 for tests 3..5. Bytes 2..3 and 9..11 read 0.
- R5: Header byte 8 reads 0xCE for the wildcard tests (1 and 4) and 0xFA for all other tests.
- R6: From byte 16 the header holds the name: a prefix of "mmio-" or "portio-", then "no-", "wildcard-" or "datamatch-", then "eventfd", then a NUL byte. The header length is 16 + name length + 1.
- R7: A read returns 0x00 when no test is active, or when address + access size is equal to or greater than the header length.
- R8: For the plain tests (0, 3) and the wildcard tests (1, 4), a write at the trigger offset through the test's own window adds one to the counter, whatever its value and size.
- R9: For the data-match tests (2, 5), a trigger write adds one to the counter only when the size is 1 and the value is 0xFA.
- R10: The counter does not change on writes to any other offset, on writes from the window of the other type, or on writes made while no test is active.
- R11: The hit counter is CNT_W bits wide and wraps modulo 2^CNT_W. Bytes 12..15 show it zero-extended, least significant byte first.
- R12: When both windows write in the same cycle, only the memory-window write takes effect. The I/O-window write is discarded.
- R13: The counter value read from bytes 12..15 includes every hit written up to the cycle before the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_wr | input | 1 | Memory-window write strobe |
| mem_addr | input | $clog2(2*MEM_BASE) (12) | Memory-window byte address, used for both reads and writes |
| mem_wdata | input | 8 | Memory-window write data |
| mem_size | input | 3 | Memory-window access size in bytes |
| mem_rdata | output | 8 | Memory-window read data (combinational) |
| io_wr | input | 1 | I/O-window write strobe |
| io_addr | input | $clog2(2*IO_BASE) (8) | I/O-window byte address, used for both reads and writes |
| io_wdata | input | 8 | I/O-window write data |
| io_size | input | 3 | I/O-window access size in bytes |
| io_rdata | output | 8 | I/O-window read data (combinational) |

## Verification
The bench keeps the default window bases of 2048 and 128, so every trigger offset and header length it checks matches the values stated above. It builds the block with CNT_W = 4, so the counter wraps after 16 hits. This puts the modulo behaviour of R11 within a short run, where a 32-bit counter would need billions of writes.

// File: rtl/whp_pkg.sv
package whp_pkg;

    localparam int KINDS = 3;
    localparam int IDX_W = 3;
    localparam int HDR_FIXED = 16;
    localparam logic [7:0] MATCH_HIT = 8'hFA;
    localparam logic [7:0] MATCH_ANY = 8'hCE;
    localparam logic [7:0] ACC_WIDTH = 8'd1;

    typedef enum logic [1:0] {
        K_PLAIN = 2'd0,
        K_WILD  = 2'd1,
        K_MATCH = 2'd2
    } kind_e;

    typedef struct packed {
        logic             active;
        logic [IDX_W-1:0] idx;
    } sel_t;

    typedef struct packed {
        logic       wr;
        logic       sel;
        logic [7:0] val;
        logic       hit;
    } wreq_t;

    function automatic logic is_io(input logic [IDX_W-1:0] idx);
        return idx >= 3'(KINDS);
    endfunction

    function automatic kind_e kind_of(input logic [IDX_W-1:0] idx);
        logic [IDX_W-1:0] k;
        k = is_io(idx) ? idx - 3'(KINDS) : idx;
        return kind_e'(k[1:0]);
    endfunction

    function automatic logic [31:0] trig_off(input logic [IDX_W-1:0] idx,
                                             input logic [31:0] mem_base,
                                             input logic [31:0] io_base);
        return (is_io(idx) ? io_base : mem_base) + {29'd0, idx};
    endfunction

    function automatic logic [7:0] match_of(input logic [IDX_W-1:0] idx);
        return (kind_of(idx) == K_WILD) ? MATCH_ANY : MATCH_HIT;
    endfunction

    function automatic int unsigned pfx_len(input logic [IDX_W-1:0] idx);
        return is_io(idx) ? 7 : 5;
    endfunction

    function automatic int unsigned mid_len(input logic [IDX_W-1:0] idx);
        case (kind_of(idx))
            K_PLAIN: return 3;
            K_WILD:  return 9;
            default: return 10;
        endcase
    endfunction

    function automatic logic [31:0] name_len(input logic [IDX_W-1:0] idx);
        return 32'(pfx_len(idx) + mid_len(idx) + 7);
    endfunction

    function automatic logic [31:0] hdr_len(input logic [IDX_W-1:0] idx);
        return 32'(HDR_FIXED) + name_len(idx) + 32'd1;
    endfunction

    // Character at position pos of the test name; 0 past its end.
    function automatic logic [7:0] name_byte(input logic [IDX_W-1:0] idx,
                                             input logic [31:0] pos);
        logic [55:0] pfx;
        logic [79:0] mid;
        logic [55:0] sfx;
        int unsigned plen, klen, p;
        p    = pos;
        sfx  = "eventfd";
        plen = pfx_len(idx);
        klen = mid_len(idx);
        pfx  = is_io(idx) ? "portio-" : {16'h0000, "mmio-"};
        case (kind_of(idx))
            K_PLAIN: mid = {56'h0, "no-"};
            K_WILD:  mid = {8'h00, "wildcard-"};
            default: mid = "datamatch-";
        endcase
        if (p < plen) return pfx[8*(plen-1-p) +: 8];
        p = p - plen;
        if (p < klen) return mid[8*(klen-1-p) +: 8];
        p = p - klen;
        if (p < 7) return sfx[8*(6-p) +: 8];
        return 8'h00;
    endfunction

    function automatic logic [7:0] hdr_byte(input logic [IDX_W-1:0] idx,
                                            input logic [31:0] cnt,
                                            input logic [31:0] pos,
                                            input logic [31:0] mem_base,
                                            input logic [31:0] io_base);
        logic [31:0] t;
        t = trig_off(idx, mem_base, io_base);
        if (pos >= 32'(HDR_FIXED)) return name_byte(idx, pos - 32'(HDR_FIXED));
        case (pos[3:0])
            4'd0:  return {5'd0, idx};
            4'd1:  return ACC_WIDTH;
            4'd4:  return t[7:0];
            4'd5:  return t[15:8];
            4'd6:  return t[23:16];
            4'd7:  return t[31:24];
            4'd8:  return match_of(idx);
            4'd12: return cnt[7:0];
            4'd13: return cnt[15:8];
            4'd14: return cnt[23:16];
            4'd15: return cnt[31:24];
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/whp_decode.sv
module whp_decode
    import whp_pkg::*;
#(
    parameter bit IS_IO    = 1'b0,
    parameter int AW       = 12,
    parameter int SIZE_W   = 3,
    parameter int MEM_BASE = 2048,
    parameter int IO_BASE  = 128
) (
    input  logic              wr,
    input  logic [AW-1:0]     addr,
    input  logic [7:0]        wdata,
    input  logic [SIZE_W-1:0] size,
    input  sel_t              cur,
    output wreq_t             req
);
    logic [31:0] a32;
    logic        own_win;
    logic        at_trig;
    logic        data_ok;

    always_comb begin
        a32     = 32'(addr);
        own_win = cur.active && (is_io(cur.idx) == IS_IO);
        at_trig = a32 == trig_off(cur.idx, 32'(MEM_BASE), 32'(IO_BASE));
        data_ok = (kind_of(cur.idx) != K_MATCH) ||
                  ((size == SIZE_W'(1)) && (wdata == MATCH_HIT));
        req.wr  = wr;
        req.sel = wr && (addr == '0);
        req.val = wdata;
        req.hit = wr && (addr != '0) && own_win && at_trig && data_ok;
    end
endmodule

// File: rtl/whp_core.sv
module whp_core
    import whp_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  wreq_t            mem_req,
    input  wreq_t            io_req,
    output sel_t             cur,
    output logic [CNT_W-1:0] cnt
);
    wreq_t            r;
    logic             r_io;
    logic             sel_ok;
    logic [IDX_W-1:0] new_idx;

    always_comb begin
        r_io    = !mem_req.wr;
        r       = r_io ? io_req : mem_req;
        sel_ok  = r.val < 8'(KINDS);
        new_idx = (r_io ? 3'(KINDS) : 3'd0) + r.val[IDX_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '0;
            cnt <= '0;
        end else if (r.sel) begin
            if (sel_ok) begin
                cur.active <= 1'b1;
                cur.idx    <= new_idx;
                cnt        <= '0;
            end else begin
                cur.active <= 1'b0;
            end
        end else if (r.hit) begin
            cnt <= cnt + 1'b1;
        end
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> !cur.active);

    assert_select_clears_R2: assert property (@(posedge clk) disable iff (rst)
        (mem_req.sel && mem_req.val < 8'd3) |=> (cur.active && cnt == '0));

    assert_bad_select_R3: assert property (@(posedge clk) disable iff (rst)
        (io_req.sel && !mem_req.wr && io_req.val >= 8'd3) |=> !cur.active);

    assert_count_step_R11: assert property (@(posedge clk) disable iff (rst)
        (cur.active && !mem_req.sel && !io_req.sel) |=>
            (cnt == $past(cnt)) || (cnt == CNT_W'($past(cnt) + 1'b1)));

    assert_idle_still_R10: assert property (@(posedge clk) disable iff (rst)
        (!cur.active && !mem_req.sel && !io_req.sel) |=> ($stable(cnt) && !cur.active));

    assert_mem_wins_R12: assert property (@(posedge clk) disable iff (rst)
        (mem_req.sel && io_req.sel && mem_req.val < 8'd3) |=>
            (cur.idx == $past(mem_req.val[IDX_W-1:0])));
endmodule

// File: rtl/whp_readport.sv
module whp_readport
    import whp_pkg::*;
#(
    parameter int AW       = 12,
    parameter int SIZE_W   = 3,
    parameter int CNT_W    = 32,
    parameter int MEM_BASE = 2048,
    parameter int IO_BASE  = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [AW-1:0]     addr,
    input  logic [SIZE_W-1:0] size,
    input  sel_t              cur,
    input  logic [CNT_W-1:0]  cnt,
    output logic [7:0]        rdata
);
    logic [31:0] a32;
    logic [31:0] last;

    always_comb begin
        a32  = 32'(addr);
        last = a32 + 32'(size);
        if (!cur.active || last >= hdr_len(cur.idx))
            rdata = 8'h00;
        else
            rdata = hdr_byte(cur.idx, 32'(cnt), a32, 32'(MEM_BASE), 32'(IO_BASE));
    end

    assert_idle_reads_zero_R7: assert property (@(posedge clk) disable iff (rst)
        !cur.active |-> rdata == 8'h00);
endmodule

// File: rtl/write_hit_probe.sv
module write_hit_probe
    import whp_pkg::*;
#(
    parameter int MEM_BASE = 2048,
    parameter int IO_BASE  = 128,
    parameter int CNT_W    = 32,
    parameter int SIZE_W   = 3,
    localparam int MEM_AW  = $clog2(2*MEM_BASE),
    localparam int IO_AW   = $clog2(2*IO_BASE)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mem_wr,
    input  logic [MEM_AW-1:0] mem_addr,
    input  logic [7:0]        mem_wdata,
    input  logic [SIZE_W-1:0] mem_size,
    output logic [7:0]        mem_rdata,
    input  logic              io_wr,
    input  logic [IO_AW-1:0]  io_addr,
    input  logic [7:0]        io_wdata,
    input  logic [SIZE_W-1:0] io_size,
    output logic [7:0]        io_rdata
);
    sel_t             cur;
    logic [CNT_W-1:0] cnt;
    wreq_t            mem_req;
    wreq_t            io_req;

    whp_decode #(.IS_IO(1'b0), .AW(MEM_AW), .SIZE_W(SIZE_W),
                 .MEM_BASE(MEM_BASE), .IO_BASE(IO_BASE)) u_mem_dec (
        .wr(mem_wr), .addr(mem_addr), .wdata(mem_wdata), .size(mem_size),
        .cur(cur), .req(mem_req));

    whp_decode #(.IS_IO(1'b1), .AW(IO_AW), .SIZE_W(SIZE_W),
                 .MEM_BASE(MEM_BASE), .IO_BASE(IO_BASE)) u_io_dec (
        .wr(io_wr), .addr(io_addr), .wdata(io_wdata), .size(io_size),
        .cur(cur), .req(io_req));

    whp_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst(rst), .mem_req(mem_req), .io_req(io_req),
        .cur(cur), .cnt(cnt));

    whp_readport #(.AW(MEM_AW), .SIZE_W(SIZE_W), .CNT_W(CNT_W),
                   .MEM_BASE(MEM_BASE), .IO_BASE(IO_BASE)) u_mem_rd (
        .clk(clk), .rst(rst), .addr(mem_addr), .size(mem_size),
        .cur(cur), .cnt(cnt), .rdata(mem_rdata));

    whp_readport #(.AW(IO_AW), .SIZE_W(SIZE_W), .CNT_W(CNT_W),
                   .MEM_BASE(MEM_BASE), .IO_BASE(IO_BASE)) u_io_rd (
        .clk(clk), .rst(rst), .addr(io_addr), .size(io_size),
        .cur(cur), .cnt(cnt), .rdata(io_rdata));
endmodule

// File: tb/write_hit_probe_test.sv
module write_hit_probe_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mem_wr = 1'b0;
    logic [11:0] mem_addr = '0;
    logic [7:0] mem_wdata = '0;
    logic [2:0] mem_size = 3'd1;
    logic [7:0] mem_rdata;
    logic       io_wr = 1'b0;
    logic [7:0] io_addr = '0;
    logic [7:0] io_wdata = '0;
    logic [2:0] io_size = 3'd1;
    logic [7:0] io_rdata;
    int total = 0;
    int fails = 0;

    always #5 clk = ~clk;

    write_hit_probe #(.CNT_W(4)) uut (
        .clk(clk), .rst(rst),
        .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_size(mem_size), .mem_rdata(mem_rdata),
        .io_wr(io_wr), .io_addr(io_addr), .io_wdata(io_wdata),
        .io_size(io_size), .io_rdata(io_rdata));

    // {io, wr, addr[11:0], data[7:0], size[2:0], expected[7:0], req[3:0]}
    localparam int NV = 45;
    localparam logic [36:0] VEC [NV] = '{
        {1'b0,1'b1,12'd0,   8'd0,  3'd1,8'h00,4'd2},  // R2 select test 0
        {1'b0,1'b0,12'd0,   8'd0,  3'd1,8'h00,4'd4},  // R4 index
        {1'b0,1'b0,12'd1,   8'd0,  3'd1,8'h01,4'd4},  // R4 width
        {1'b0,1'b0,12'd4,   8'd0,  3'd1,8'h00,4'd4},  // R4 trigger low
        {1'b0,1'b0,12'd5,   8'd0,  3'd1,8'h08,4'd4},  // R4 trigger high
        {1'b0,1'b0,12'd8,   8'd0,  3'd1,8'hFA,4'd5},  // R5
        {1'b0,1'b0,12'd16,  8'd0,  3'd1,8'h6D,4'd6},  // R6 'm'
        {1'b0,1'b1,12'd2048,8'h12, 3'd1,8'h00,4'd8},  // R8 hit
        {1'b0,1'b1,12'd2048,8'h34, 3'd2,8'h00,4'd8},  // R8 hit, size 2
        {1'b0,1'b1,12'd2049,8'h00, 3'd1,8'h00,4'd10}, // R10 wrong offset
        {1'b0,1'b0,12'd12,  8'd0,  3'd1,8'h02,4'd13}, // R13 count 2
        {1'b1,1'b1,12'd0,   8'd1,  3'd1,8'h00,4'd2},  // R2 select test 4
        {1'b1,1'b0,12'd0,   8'd0,  3'd1,8'h04,4'd2},  // R2 index 4
        {1'b1,1'b0,12'd4,   8'd0,  3'd1,8'h84,4'd4},  // R4 trigger 132
        {1'b1,1'b0,12'd8,   8'd0,  3'd1,8'hCE,4'd5},  // R5 wildcard
        {1'b1,1'b0,12'd12,  8'd0,  3'd1,8'h00,4'd2},  // R2 cleared
        {1'b1,1'b0,12'd16,  8'd0,  3'd1,8'h70,4'd6},  // R6 'p'
        {1'b1,1'b0,12'd23,  8'd0,  3'd1,8'h77,4'd6},  // R6 'w'
        {1'b1,1'b1,12'd132, 8'h00, 3'd4,8'h00,4'd8},  // R8 hit
        {1'b0,1'b1,12'd132, 8'h00, 3'd1,8'h00,4'd10}, // R10 other window
        {1'b0,1'b0,12'd12,  8'd0,  3'd1,8'h01,4'd10}, // R10 count stays 1
        {1'b0,1'b1,12'd0,   8'd2,  3'd1,8'h00,4'd2},  // select test 2
        {1'b0,1'b1,12'd2050,8'hFA, 3'd1,8'h00,4'd9},  // R9 hit
        {1'b0,1'b1,12'd2050,8'hFB, 3'd1,8'h00,4'd9},  // R9 wrong value
        {1'b0,1'b1,12'd2050,8'hFA, 3'd2,8'h00,4'd9},  // R9 wrong size
        {1'b0,1'b0,12'd12,  8'd0,  3'd1,8'h01,4'd9},  // R9 count 1
        {1'b0,1'b0,12'd37,  8'd0,  3'd1,8'h64,4'd6},  // R6 last 'd'
        {1'b0,1'b0,12'd38,  8'd0,  3'd1,8'h00,4'd7},  // R7 at length
        {1'b0,1'b0,12'd36,  8'd0,  3'd2,8'h66,4'd7},  // R7 'f' size 2
        {1'b0,1'b0,12'd37,  8'd0,  3'd2,8'h00,4'd7},  // R7 size 2 overrun
        {1'b0,1'b1,12'd0,   8'd3,  3'd1,8'h00,4'd3},  // R3 stop
        {1'b0,1'b0,12'd1,   8'd0,  3'd1,8'h00,4'd3},  // R3 idle width
        {1'b0,1'b1,12'd2050,8'hFA, 3'd1,8'h00,4'd10}, // R10 idle write
        {1'b1,1'b1,12'd0,   8'd0,  3'd1,8'h00,4'd2},  // select test 3
        {1'b1,1'b0,12'd0,   8'd0,  3'd1,8'h03,4'd2},  // R2 index 3
        {1'b1,1'b0,12'd9,   8'd0,  3'd1,8'h00,4'd4},  // R4 pad
        {1'b1,1'b0,12'd8,   8'd0,  3'd1,8'hFA,4'd5},  // R5 plain
        {1'b1,1'b1,12'd131, 8'h55, 3'd1,8'h00,4'd8},  // R8 hit
        {1'b1,1'b0,12'd12,  8'd0,  3'd1,8'h01,4'd8},  // R8 count 1
        {1'b1,1'b1,12'd0,   8'd2,  3'd1,8'h00,4'd2},  // select test 5
        {1'b1,1'b0,12'd0,   8'd0,  3'd1,8'h05,4'd2},  // R2 index 5
        {1'b1,1'b0,12'd39,  8'd0,  3'd1,8'h64,4'd6},  // R6 last 'd'
        {1'b1,1'b0,12'd39,  8'd0,  3'd2,8'h00,4'd7},  // R7 overrun
        {1'b0,1'b1,12'd0,   8'd1,  3'd1,8'h00,4'd2},  // select test 1
        {1'b0,1'b0,12'd4,   8'd0,  3'd1,8'h01,4'd4}   // R4 trigger 2049
    };

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input int req);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R%0d: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic op(input logic io, input logic wr, input logic [11:0] addr,
                      input logic [7:0] data, input logic [2:0] size,
                      input logic [7:0] exp, input int req);
        @(negedge clk);
        if (io) begin
            io_wr = wr; io_addr = addr[7:0]; io_wdata = data; io_size = size;
        end else begin
            mem_wr = wr; mem_addr = addr; mem_wdata = data; mem_size = size;
        end
        if (wr) begin
            @(posedge clk);
            #1;
            mem_wr = 1'b0;
            io_wr  = 1'b0;
        end else begin
            #1;
            check(io ? io_rdata : mem_rdata, exp, req);
        end
    endtask

    initial begin
        #2000000;
        fails++;
        total++;
        $display("FAIL watchdog: got hang expected finish");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1: reset state reads zero
        op(1'b0, 1'b0, 12'd1, 8'd0, 3'd1, 8'h00, 1);
        op(1'b1, 1'b0, 12'd1, 8'd0, 3'd1, 8'h00, 1);
        op(1'b0, 1'b0, 12'd0, 8'd0, 3'd1, 8'h00, 1);

        for (int i = 0; i < NV; i++)
            op(VEC[i][36], VEC[i][35], VEC[i][34:23], VEC[i][22:15],
               VEC[i][14:12], VEC[i][11:4], int'(VEC[i][3:0]));

        // R11: test 1 active, 17 wildcard hits wrap a 4-bit counter to 1
        for (int k = 0; k < 17; k++)
            op(1'b0, 1'b1, 12'd2049, 8'(k), 3'd4, 8'h00, 11);
        op(1'b0, 1'b0, 12'd12, 8'd0, 3'd1, 8'h01, 11);
        op(1'b0, 1'b0, 12'd13, 8'd0, 3'd1, 8'h00, 11);

        // R12: both windows select in one cycle; memory wins
        @(negedge clk);
        mem_wr = 1'b1; mem_addr = 12'd0; mem_wdata = 8'd2; mem_size = 3'd1;
        io_wr  = 1'b1; io_addr = 8'd0;   io_wdata = 8'd0;  io_size = 3'd1;
        @(posedge clk); #1; mem_wr = 1'b0; io_wr = 1'b0;
        op(1'b0, 1'b0, 12'd0, 8'd0, 3'd1, 8'h02, 12);
        // R12: ignored memory write still blocks an I/O select
        @(negedge clk);
        mem_wr = 1'b1; mem_addr = 12'd2050; mem_wdata = 8'hFB; mem_size = 3'd1;
        io_wr  = 1'b1; io_addr = 8'd0;      io_wdata = 8'd1;  io_size = 3'd1;
        @(posedge clk); #1; mem_wr = 1'b0; io_wr = 1'b0;
        op(1'b1, 1'b0, 12'd0, 8'd0, 3'd1, 8'h02, 12);
        op(1'b1, 1'b0, 12'd12, 8'd0, 3'd1, 8'h00, 12);

        // R1: reset in the middle of a test
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        op(1'b0, 1'b0, 12'd1, 8'd0, 3'd1, 8'h00, 1);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule